// File: doc/BRIEF.md
# Vector Branch-to-Predicate Compare Unit

This block sits beside the branch decoder of a vector-capable integer pipeline. When a conditional branch names a register that has been marked as vectorised, the branch does not redirect the program counter. It becomes an element-wise compare instead. The two source elements at the current vector element index are compared. A single result bit, 1 when the condition holds and 0 when it does not, is then written into one bit of a predicate register. The bits that held the branch offset now name that predicate register.

The caller reads the two element operands from the register file and presents them together with the instruction word, the vectorised flag and the element index. One clock later the block returns a predicate write: the target register, a bit position, a one-hot bit mask and the bit value. It can instead raise a fallback flag, which tells the pipeline to run the instruction as an ordinary branch. In the compressed form, a floating-point compare is only flagged, together with its comparison code, for a separate float unit. Greater-than and greater-or-equal have no codes of their own: software swaps the source fields. The 32-bit greater-or-equal branch is handled inside the block by swapping the operands.

Top module: `vec_cmp_pred`

## Requirements
- R1: A 32-bit conditional branch (bits 6:0 = 1100011) with in_valid and vec_flag high produces, on the next clock edge, pred_wen = 1 and pred_reg = instruction bits 11:7.
- R2: On a predicate write, pred_idx equals the elem_idx presented one cycle earlier and pred_mask is one-hot with only bit pred_idx set. When there is no predicate write, pred_mask is zero.
- R3: 32-bit funct3 (bits 14:12) 000 tests a==b, 001 tests a!=b, 100 tests signed a<b and 101 tests signed a>=b. pred_val is 1 exactly when the test holds.
- R4: A 32-bit branch whose funct3 is 010, 011, 110 or 111 raises fallback and writes no predicate.
- R5: Instruction bits 31:25 of the 32-bit form are reserved and have no effect on the result.
- R6: The compressed form has bits 1:0 = 01 and bits 15:14 = 11, and bit 13 is the low bit of funct3. It writes predicate register 8 + bits 12:10. The code {bit5, bit13} selects a signed compare of a and b: 00 selects EQ, 01 NEQ, 10 LT and 11 LE.
- R7: In the compressed form, bit 6 = 1 selects a floating-point compare. The block then raises fp_sel, gives the predicate register in pred_reg and the {bit5, bit13} code in fp_op, and writes no predicate bit.
- R8: A recognised branch with vec_flag low raises fallback and writes no predicate. fallback and pred_wen are never high together.
- R9: When in_valid is low, or the instruction is not a recognised branch, pred_wen, fallback and fp_sel are low on the next cycle.
- R10: While rst_n is low at a clock edge, every output is cleared on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| insn | input | 32 | Instruction word; a compressed instruction sits in bits 15:0 |
| vec_flag | input | 1 | The branch refers to a vectorised register |
| elem_idx | input | IDX_W (6) | Current vector element index |
| src_a | input | XLEN (64) | Element operand for source 1 |
| src_b | input | XLEN (64) | Element operand for source 2 |
| pred_wen | output | 1 | Predicate bit write enable |
| pred_reg | output | 5 | Predicate register to write |
| pred_idx | output | IDX_W (6) | Bit position within the predicate register |
| pred_mask | output | PRED_W (64) | One-hot write mask |
| pred_val | output | 1 | Bit value to write |
| fp_sel | output | 1 | A floating-point compare is requested |
| fp_op | output | 2 | Comparison code for the float unit |
| fallback | output | 1 | Execute as a normal branch |

## Verification
Two decisions are made for every branch in the same cycle: whether it becomes a predicate write and whether it falls back to a normal branch. The stimulus table is applied back to back, one instruction per clock. Vectorised and scalar branches, unsupported funct3 codes and non-branch words follow one another, so the registered outputs change in every cycle. Each cycle the bench checks that exactly the expected one of pred_wen, fallback and fp_sel is high. The checker also watches at every edge that fallback and pred_wen are never high together.

// File: rtl/vcp_pkg.sv
// Package for the vector branch-to-predicate unit.
// Holds the comparison code and the decoded-instruction record shared
// by the decoder, the comparator and the top level.
package vcp_pkg;

    // Comparison codes; the value is also the compressed {bit5, bit13} field.
    typedef enum logic [1:0] {
        CMP_EQ = 2'b00,
        CMP_NE = 2'b01,
        CMP_LT = 2'b10,
        CMP_LE = 2'b11
    } cmp_op_e;

    // Result of decoding one instruction word.
    typedef struct packed {
        logic       is_br;   // recognised branch encoding
        logic       bad_f3;  // branch form with no predicate meaning
        logic       is_fp;   // float compare requested (compressed only)
        logic       swap;    // exchange the operands before comparing
        cmp_op_e    op;      // comparison to perform
        logic [4:0] preg;    // predicate target register
    } dec_t;

endpackage

// File: rtl/vcp_decode.sv
// Instruction decoder for the branch-to-predicate unit.
// Recognises 32-bit conditional branches and the two compressed
// branch-on-zero slots, and returns a dec_t record.
// Assumes a compressed instruction occupies insn[15:0].
module vcp_decode
    import vcp_pkg::*;
(
    input  logic [31:0] insn,
    output dec_t        dec
);

    localparam logic [6:0] OPC_BRANCH = 7'b1100011;

    // Purely combinational field extraction and op selection.
    always_comb begin
        dec = '0;
        if (insn[1:0] == 2'b11 && insn[6:0] == OPC_BRANCH) begin
            dec.is_br = 1'b1;
            dec.preg  = insn[11:7];
            unique case (insn[14:12])
                3'b000:  dec.op = CMP_EQ;
                3'b001:  dec.op = CMP_NE;
                3'b100:  dec.op = CMP_LT;
                3'b101: begin
                    dec.op   = CMP_LE;   // a >= b is b <= a
                    dec.swap = 1'b1;
                end
                default: dec.bad_f3 = 1'b1;
            endcase
        end else if (insn[1:0] == 2'b01 && insn[15:14] == 2'b11) begin
            dec.is_br = 1'b1;
            dec.preg  = {2'b01, insn[12:10]};
            dec.is_fp = insn[6];
            dec.op    = cmp_op_e'({insn[5], insn[13]});
        end
    end

endmodule

// File: rtl/vcp_compare.sv
// Signed integer element comparator.
// Optionally exchanges the operands, then evaluates EQ, NEQ, LT or LE.
module vcp_compare
    import vcp_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            swap,
    input  cmp_op_e         op,
    output logic            hit
);

    logic [XLEN-1:0] lhs, rhs;
    logic            eq, lt;

    // Operand ordering and the two primitive relations.
    always_comb begin
        lhs = swap ? b : a;
        rhs = swap ? a : b;
        eq  = (lhs == rhs);
        lt  = ($signed(lhs) < $signed(rhs));
    end

    // Select the requested relation.
    always_comb begin
        unique case (op)
            CMP_EQ: hit = eq;
            CMP_NE: hit = !eq;
            CMP_LT: hit = lt;
            CMP_LE: hit = lt || eq;
        endcase
    end

endmodule

// File: rtl/vcp_bitsel.sv
// Element-index to one-hot write mask, gated by an enable.
module vcp_bitsel #(
    parameter int PRED_W = 64,
    localparam int IDX_W = $clog2(PRED_W)
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic              en,
    output logic [PRED_W-1:0] mask
);

    // One comparator per predicate bit.
    for (genvar i = 0; i < PRED_W; i++) begin : g_bit
        assign mask[i] = en && (idx == IDX_W'(i));
    end

endmodule

// File: rtl/vec_cmp_pred.sv
// Vector branch-to-predicate compare unit (top level).
// A branch on a vectorised register becomes one element compare whose
// result is written to one bit of a predicate register. Scalar branches
// are handed back through the fallback flag. One register stage.
// Assumes src_a/src_b are the elements already read for this index.
module vec_cmp_pred
    import vcp_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int PRED_W = 64,
    localparam int IDX_W = $clog2(PRED_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       insn,
    input  logic              vec_flag,
    input  logic [IDX_W-1:0]  elem_idx,
    input  logic [XLEN-1:0]   src_a,
    input  logic [XLEN-1:0]   src_b,
    output logic              pred_wen,
    output logic [4:0]        pred_reg,
    output logic [IDX_W-1:0]  pred_idx,
    output logic [PRED_W-1:0] pred_mask,
    output logic              pred_val,
    output logic              fp_sel,
    output logic [1:0]        fp_op,
    output logic              fallback
);

    dec_t              dec;
    logic              hit;
    logic              wen_n, fb_n, fp_n;
    logic [PRED_W-1:0] mask_n;

    vcp_decode u_dec (
        .insn (insn),
        .dec  (dec)
    );

    vcp_compare #(.XLEN(XLEN)) u_cmp (
        .a    (src_a),
        .b    (src_b),
        .swap (dec.swap),
        .op   (dec.op),
        .hit  (hit)
    );

    vcp_bitsel #(.PRED_W(PRED_W)) u_sel (
        .idx  (elem_idx),
        .en   (wen_n),
        .mask (mask_n)
    );

    // Route each valid branch to exactly one outcome.
    always_comb begin
        wen_n = in_valid && dec.is_br && vec_flag && !dec.bad_f3 && !dec.is_fp;
        fp_n  = in_valid && dec.is_br && vec_flag && !dec.bad_f3 && dec.is_fp;
        fb_n  = in_valid && dec.is_br && (!vec_flag || dec.bad_f3);
    end

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_wen  <= 1'b0;
            pred_reg  <= '0;
            pred_idx  <= '0;
            pred_mask <= '0;
            pred_val  <= 1'b0;
            fp_sel    <= 1'b0;
            fp_op     <= '0;
            fallback  <= 1'b0;
        end else begin
            pred_wen  <= wen_n;
            pred_reg  <= (wen_n || fp_n) ? dec.preg : 5'd0;
            pred_idx  <= wen_n ? elem_idx : '0;
            pred_mask <= mask_n;
            pred_val  <= wen_n && hit;
            fp_sel    <= fp_n;
            fp_op     <= fp_n ? dec.op : 2'b00;
            fallback  <= fb_n;
        end
    end

endmodule

// File: rtl/vcp_checker.sv
// Property checker for vec_cmp_pred, attached by bind below.
module vcp_checker #(
    parameter int XLEN   = 64,
    parameter int PRED_W = 64,
    localparam int IDX_W = $clog2(PRED_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [31:0]       insn,
    input logic              vec_flag,
    input logic [IDX_W-1:0]  elem_idx,
    input logic [XLEN-1:0]   src_a,
    input logic [XLEN-1:0]   src_b,
    input logic              pred_wen,
    input logic [4:0]        pred_reg,
    input logic [IDX_W-1:0]  pred_idx,
    input logic [PRED_W-1:0] pred_mask,
    input logic              pred_val,
    input logic              fp_sel,
    input logic [1:0]        fp_op,
    input logic              fallback
);

    assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pred_wen && fallback));

    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pred_wen |-> ($countones(pred_mask) == 1 && pred_mask[pred_idx]));

    assert_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vec_flag) |=> (!pred_wen || pred_idx == $past(elem_idx)));

    assert_novec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !vec_flag) |=> !pred_wen);

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!pred_wen && !fallback && !fp_sel));

    assert_fpx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fp_sel |-> (!pred_wen && !pred_val && $countones(pred_mask) == 0));

    assert_creg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vec_flag && insn[1:0] == 2'b01) |=>
            (!pred_wen || pred_reg[4:3] == 2'b01));

endmodule

bind vec_cmp_pred vcp_checker #(.XLEN(XLEN), .PRED_W(PRED_W)) u_chk (.*);

// File: tb/vec_cmp_pred_bench.sv
// Self-checking bench: table of back-to-back vectors, then directed cases.
module vec_cmp_pred_bench;

    localparam int XLEN   = 64;
    localparam int PRED_W = 64;
    localparam int IDX_W  = 6;

    typedef struct packed {
        logic [31:0] insn;
        logic        vec;
        logic [5:0]  idx;
        logic [63:0] a;
        logic [63:0] b;
        logic        ewen;
        logic        efb;
        logic        efp;
        logic [4:0]  ereg;
        logic        eval;
        logic [3:0]  req;
    } row_t;

    function automatic logic [31:0] br32(input logic [2:0] f3, input logic [4:0] pd);
        return {7'd0, 5'd2, 5'd1, f3, pd, 7'b1100011};
    endfunction

    function automatic logic [31:0] cbr(input logic f0, input logic b6,
                                        input logic b5, input logic [2:0] pd);
        return {16'd0, 2'b11, f0, pd, 3'd1, b6, b5, 3'd2, 2'b01};
    endfunction

    localparam int NROW = 21;
    localparam row_t TBL [NROW] = '{
        '{br32(3'b000, 5'd5),  1'b1, 6'd3,  64'd7,  64'd7,  1'b1, 1'b0, 1'b0, 5'd5,  1'b1, 4'd1}, // R1 BEQ hit
        '{br32(3'b000, 5'd5),  1'b1, 6'd0,  64'd7,  64'd8,  1'b1, 1'b0, 1'b0, 5'd5,  1'b0, 4'd3}, // R3 BEQ miss
        '{br32(3'b001, 5'd31), 1'b1, 6'd63, 64'd7,  64'd8,  1'b1, 1'b0, 1'b0, 5'd31, 1'b1, 4'd3}, // R3 BNE, top index
        '{br32(3'b100, 5'd2),  1'b1, 6'd10, -64'd1, 64'd1,  1'b1, 1'b0, 1'b0, 5'd2,  1'b1, 4'd3}, // R3 BLT signed
        '{br32(3'b100, 5'd2),  1'b1, 6'd11, 64'd1,  -64'd1, 1'b1, 1'b0, 1'b0, 5'd2,  1'b0, 4'd3}, // R3 BLT signed
        '{br32(3'b101, 5'd4),  1'b1, 6'd12, 64'd5,  64'd5,  1'b1, 1'b0, 1'b0, 5'd4,  1'b1, 4'd3}, // R3 BGE equal
        '{br32(3'b101, 5'd4),  1'b1, 6'd13, -64'd3, 64'd2,  1'b1, 1'b0, 1'b0, 5'd4,  1'b0, 4'd3}, // R3 BGE miss
        '{br32(3'b101, 5'd4),  1'b1, 6'd14, 64'd2,  -64'd3, 1'b1, 1'b0, 1'b0, 5'd4,  1'b1, 4'd3}, // R3 BGE hit
        '{br32(3'b010, 5'd6),  1'b1, 6'd1,  64'd0,  64'd0,  1'b0, 1'b1, 1'b0, 5'd0,  1'b0, 4'd4}, // R4
        '{br32(3'b110, 5'd6),  1'b1, 6'd1,  64'd0,  64'd0,  1'b0, 1'b1, 1'b0, 5'd0,  1'b0, 4'd4}, // R4
        '{br32(3'b000, 5'd9) | 32'hFE00_0000,
                               1'b1, 6'd20, 64'd9,  64'd9,  1'b1, 1'b0, 1'b0, 5'd9,  1'b1, 4'd5}, // R5
        '{cbr(1'b0, 1'b0, 1'b0, 3'd3), 1'b1, 6'd2, 64'd4, 64'd4, 1'b1, 1'b0, 1'b0, 5'd11, 1'b1, 4'd6}, // R6 EQ
        '{cbr(1'b1, 1'b0, 1'b0, 3'd0), 1'b1, 6'd5, 64'd4, 64'd4, 1'b1, 1'b0, 1'b0, 5'd8,  1'b0, 4'd6}, // R6 NEQ
        '{cbr(1'b0, 1'b0, 1'b1, 3'd7), 1'b1, 6'd6, -64'd5, -64'd4, 1'b1, 1'b0, 1'b0, 5'd15, 1'b1, 4'd6}, // R6 LT
        '{cbr(1'b1, 1'b0, 1'b1, 3'd7), 1'b1, 6'd7, -64'd4, -64'd4, 1'b1, 1'b0, 1'b0, 5'd15, 1'b1, 4'd6}, // R6 LE
        '{cbr(1'b1, 1'b0, 1'b1, 3'd7), 1'b1, 6'd8, -64'd3, -64'd4, 1'b1, 1'b0, 1'b0, 5'd15, 1'b0, 4'd6}, // R6 LE
        '{cbr(1'b0, 1'b1, 1'b0, 3'd2), 1'b1, 6'd9, 64'd4, 64'd4, 1'b0, 1'b0, 1'b1, 5'd10, 1'b0, 4'd7}, // R7
        '{br32(3'b000, 5'd5),  1'b0, 6'd3,  64'd7,  64'd7,  1'b0, 1'b1, 1'b0, 5'd0,  1'b0, 4'd8}, // R8
        '{cbr(1'b0, 1'b0, 1'b0, 3'd3), 1'b0, 6'd2, 64'd4, 64'd4, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0, 4'd8}, // R8
        '{32'h0000_0013,       1'b1, 6'd4,  64'd1,  64'd1,  1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 4'd9}, // R9
        '{32'h0000_0001,       1'b1, 6'd4,  64'd1,  64'd1,  1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 4'd9}  // R9
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [31:0]       insn;
    logic              vec_flag;
    logic [IDX_W-1:0]  elem_idx;
    logic [XLEN-1:0]   src_a, src_b;
    logic              pred_wen, pred_val, fp_sel, fallback;
    logic [4:0]        pred_reg;
    logic [IDX_W-1:0]  pred_idx;
    logic [PRED_W-1:0] pred_mask;
    logic [1:0]        fp_op;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = !clk;   // 50 MHz

    vec_cmp_pred #(.XLEN(XLEN), .PRED_W(PRED_W)) u_vec_cmp_pred (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .vec_flag(vec_flag), .elem_idx(elem_idx), .src_a(src_a), .src_b(src_b),
        .pred_wen(pred_wen), .pred_reg(pred_reg), .pred_idx(pred_idx),
        .pred_mask(pred_mask), .pred_val(pred_val), .fp_sel(fp_sel),
        .fp_op(fp_op), .fallback(fallback)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input row_t r);
        in_valid = 1'b1;
        insn     = r.insn;
        vec_flag = r.vec;
        elem_idx = r.idx;
        src_a    = r.a;
        src_b    = r.b;
    endtask

    task automatic check_row(input row_t r);
        string tag;
        tag = $sformatf("R%0d", r.req);
        check(tag, "pred_wen", 64'(pred_wen), 64'(r.ewen));
        check(tag, "fallback", 64'(fallback), 64'(r.efb));
        check(tag, "fp_sel",   64'(fp_sel),   64'(r.efp));
        if (r.ewen || r.efp)
            check(tag, "pred_reg", 64'(pred_reg), 64'(r.ereg));
        check(tag, "pred_val", 64'(pred_val), 64'(r.eval));
        // R2: mask is one-hot at the index only on a write
        check("R2", "pred_mask", pred_mask, r.ewen ? (64'd1 << r.idx) : 64'd0);
        if (r.ewen)
            check("R2", "pred_idx", 64'(pred_idx), 64'(r.idx));
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // R10: reset clears outputs even with a valid vector branch present
        rst_n = 1'b0;
        drive(TBL[0]);
        repeat (3) @(negedge clk);
        check("R10", "pred_wen", 64'(pred_wen), 64'd0);
        check("R10", "fallback", 64'(fallback), 64'd0);
        check("R10", "pred_mask", pred_mask, 64'd0);
        check("R10", "pred_reg", 64'(pred_reg), 64'd0);
        rst_n = 1'b1;

        // Table, applied back to back: check row i while driving row i+1
        drive(TBL[0]);
        for (int i = 0; i < NROW; i++) begin
            @(negedge clk);
            check_row(TBL[i]);
            if (i + 1 < NROW) drive(TBL[i + 1]);
        end

        // R7: float compare carries its code {bit5, bit13}
        drive(TBL[0]);
        insn = cbr(1'b1, 1'b1, 1'b1, 3'd1);
        @(negedge clk);
        check("R7", "fp_sel", 64'(fp_sel), 64'd1);
        check("R7", "fp_op", 64'(fp_op), 64'd3);
        check("R7", "pred_reg", 64'(pred_reg), 64'd9);

        // R9: a vector branch without in_valid does nothing
        drive(TBL[0]);
        in_valid = 1'b0;
        @(negedge clk);
        check("R9", "pred_wen", 64'(pred_wen), 64'd0);
        check("R9", "fallback", 64'(fallback), 64'd0);
        check("R9", "pred_mask", pred_mask, 64'd0);

        // R10: reset asserted mid-stream clears a pending write
        drive(TBL[0]);
        @(negedge clk);
        check("R1", "pred_wen", 64'(pred_wen), 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", "pred_wen", 64'(pred_wen), 64'd0);
        check("R10", "pred_val", 64'(pred_val), 64'd0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        summary();
    end

endmodule